// File: doc/BRIEF.md
# Third-Order Programmable-Modulus Sigma-Delta Divider Sequencer

This block supplies the instantaneous feedback-divide value for a fractional-N frequency loop. Each accepted output is an integer N near the programmed integer part. Over time the mean of the accepted values converges to INT + FRAC/MOD. The noise shaping is third order. Three first-order error-feedback accumulators are chained, and each one wraps at a programmable modulus from 2 to 4095 rather than at a power of two. Their carries are then merged through first and second differences.

Configuration enters on plain pins and is captured only on the update strobe. A capture also restarts the modulator from an all-zero state, so a given setting always gives the same sequence. A separate counter-reset input holds the modulator cleared and withdraws the output for as long as it is high.

An optional dither mode feeds a pseudo-random least significant bit into the first accumulator. Dither takes effect only when the modulus is at least 50.

The divide values leave on a valid/ready stream. The modulator advances only when a value is accepted, which is a cycle with both out_valid and out_ready high. While out_ready is low, the presented value and all internal state hold, so a consumer can apply back-pressure for any number of cycles without changing the sequence it receives.

Top module: `sdm_fracn_top`

## Requirements
- R1: While out_valid is high and the captured INT is at least 3, out_n lies between INT-3 and INT+4 inclusive.
- R2: With dither off and FRAC below MOD, the sum S of the first M values accepted after a restart satisfies M*INT + floor(M*FRAC/MOD) - 1 <= S <= M*INT + floor(M*FRAC/MOD) + 2.
- R3: With FRAC equal to 0 and dither not in effect, every presented value equals INT exactly.
- R4: Every accumulator residue stays below the captured MOD, so the wrap point is the programmed modulus (for example 7, 1000 or 4095), not a power of two.
- R5: A cycle with upd_strobe high captures int_val, frac_val, mod_val and dither_en and clears all accumulators and carry delays. Two captures of the same setting give identical sequences, whatever setting came between them.
- R6: A cycle with cnt_reset high clears the modulator and drives out_valid low on the next cycle. When cnt_reset is low again, out_valid returns high one cycle later and the sequence starts over from its first value.
- R7: While out_valid is high and out_ready is low, out_n and the modulator state hold into the next cycle. The sequence of accepted values does not depend on the stall pattern.
- R8: When dither_en is captured high and MOD is at least 50, a pseudo-random bit is added to the first accumulator input, so FRAC = 0 yields values other than INT. With MOD below 50, captured dither has no effect.
- R9: While rst_n is low, out_valid is 0. After release the captured setting is INT = 0, FRAC = 0, MOD = 2 with dither off, so the first valid value is 0.
- R10: Changes on int_val, frac_val, mod_val and dither_en while upd_strobe is low do not alter out_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-comparison clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_reset | input | 1 | Holds the modulator cleared and the output invalid while high |
| upd_strobe | input | 1 | Captures the configuration pins and restarts the modulator |
| int_val | input | 9 | Integer part of the divide ratio |
| frac_val | input | 12 | Fractional numerator; must be below mod_val |
| mod_val | input | 12 | Modulus, 2 to 4095 |
| dither_en | input | 1 | Requests dither of the first accumulator |
| out_valid | output | 1 | A divide value is presented |
| out_ready | input | 1 | Consumer accepts the presented value |
| out_n | output | 10 | Instantaneous divide value |

## Verification
A residue that wraps at the wrong point, or a carry that is lost or counted twice, makes the running sum of accepted values leave the three-count band around M*INT + floor(M*FRAC/MOD). With a small modulus this shows within one or two modulus periods. A wrong weight in the difference network gives values outside INT-3..INT+4, or a drift that grows without bound. A delay register that is not cleared, or a generator state that is not restarted, breaks the repeatability of the sequence, so the first accepted values after a restart differ from a recorded run. State that advances during a stall shows as a changed out_n on the very next cycle.

// File: rtl/sdm_fracn_pkg.sv
package sdm_fracn_pkg;
  localparam int SDM_ORDER = 3;
  localparam int DITH_LFSR_W = 23;
  localparam int DITH_LFSR_TAP = 18;
  localparam int DITH_MIN_MOD_DEF = 50;
  typedef logic [SDM_ORDER-1:0] carry_vec_t;
endpackage

// File: rtl/sdm_mod_stage.sv
module sdm_mod_stage #(
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [MOD_W:0]   add_in,
  input  logic [MOD_W-1:0] modulus,
  output logic             carry,
  output logic [MOD_W-1:0] resid,
  output logic [MOD_W-1:0] acc
);
  localparam int SUM_W = MOD_W + 2;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    sum     = SUM_W'(acc) + SUM_W'(add_in);
    carry   = (sum >= SUM_W'(modulus));
    wrapped = sum - SUM_W'(modulus);
    resid   = carry ? wrapped[MOD_W-1:0] : sum[MOD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      acc <= '0;
    else if (step)
      acc <= resid;
  end
endmodule

// File: rtl/sdm_dither_lfsr.sv
module sdm_dither_lfsr #(
  parameter int         W    = 23,
  parameter int         TAP  = 18,
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic bit_o
);
  logic [W-1:0] state;
  logic         fb;

  assign fb    = state[W-1] ^ state[TAP-1];
  assign bit_o = state[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      state <= SEED;
    else if (step)
      state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/sdm_noise_combiner.sv
module sdm_noise_combiner
  import sdm_fracn_pkg::*;
#(
  parameter int INT_W = 9,
  parameter int OUT_W = INT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  carry_vec_t       carry,
  input  logic [INT_W-1:0] int_part,
  output logic [OUT_W-1:0] n_out
);
  logic c2_d1, c3_d1, c3_d2;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      c2_d1 <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else if (step) begin
      c2_d1 <= carry[1];
      c3_d1 <= carry[2];
      c3_d2 <= c3_d1;
    end
  end

  always_comb begin
    n_out = OUT_W'(int_part)
          + OUT_W'(carry[0])
          + OUT_W'(carry[1]) - OUT_W'(c2_d1)
          + OUT_W'(carry[2]) - (OUT_W'(c3_d1) << 1) + OUT_W'(c3_d2);
  end
endmodule

// File: rtl/sdm_fracn_top.sv
module sdm_fracn_top
  import sdm_fracn_pkg::*;
#(
  parameter int INT_W        = 9,
  parameter int FRAC_W       = 12,
  parameter int MOD_W        = 12,
  parameter int MOD_RST      = 2,
  parameter int DITH_MIN_MOD = DITH_MIN_MOD_DEF,
  parameter int LFSR_W       = DITH_LFSR_W,
  parameter int LFSR_TAP     = DITH_LFSR_TAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_reset,
  input  logic              upd_strobe,
  input  logic [INT_W-1:0]  int_val,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic [MOD_W-1:0]  mod_val,
  input  logic              dither_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [INT_W:0]    out_n
);
  localparam int OUT_W  = INT_W + 1;
  localparam int STAGES = SDM_ORDER;

  logic [INT_W-1:0]  cfg_int;
  logic [FRAC_W-1:0] cfg_frac;
  logic [MOD_W-1:0]  cfg_mod;
  logic              cfg_dith;
  logic              dith_on;
  logic              dith_bit;
  logic              step;
  logic              clr;

  logic [MOD_W:0]                 stg_in [STAGES];
  logic [MOD_W-1:0]               resid  [STAGES];
  logic [STAGES-1:0][MOD_W-1:0]   acc_vec;
  carry_vec_t                     carry;

  assign step    = out_valid && out_ready;
  assign clr     = upd_strobe || cnt_reset;
  assign dith_on = cfg_dith && (cfg_mod >= MOD_W'(DITH_MIN_MOD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_int  <= '0;
      cfg_frac <= '0;
      cfg_mod  <= MOD_W'(MOD_RST);
      cfg_dith <= 1'b0;
    end else if (upd_strobe) begin
      cfg_int  <= int_val;
      cfg_frac <= frac_val;
      cfg_mod  <= mod_val;
      cfg_dith <= dither_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      out_valid <= 1'b0;
    else
      out_valid <= !cnt_reset;
  end

  sdm_dither_lfsr #(
    .W   (LFSR_W),
    .TAP (LFSR_TAP)
  ) dith_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .step  (step),
    .bit_o (dith_bit)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stg_in[k] = (MOD_W+1)'(cfg_frac) + (MOD_W+1)'(dith_bit && dith_on);
    end else begin : g_tail
      assign stg_in[k] = {1'b0, resid[k-1]};
    end

    sdm_mod_stage #(
      .MOD_W (MOD_W)
    ) stage_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .step    (step),
      .add_in  (stg_in[k]),
      .modulus (cfg_mod),
      .carry   (carry[k]),
      .resid   (resid[k]),
      .acc     (acc_vec[k])
    );
  end

  sdm_noise_combiner #(
    .INT_W (INT_W),
    .OUT_W (OUT_W)
  ) comb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .step     (step),
    .carry    (carry),
    .int_part (cfg_int),
    .n_out    (out_n)
  );
endmodule

// File: rtl/sdm_fracn_chk.sv
module sdm_fracn_chk #(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 12,
  parameter int MOD_W  = 12,
  parameter int STAGES = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             cnt_reset,
  input logic                             upd_strobe,
  input logic                             out_valid,
  input logic                             out_ready,
  input logic [INT_W:0]                   out_n,
  input logic [INT_W-1:0]                 cfg_int,
  input logic [FRAC_W-1:0]                cfg_frac,
  input logic [MOD_W-1:0]                 cfg_mod,
  input logic                             dith_on,
  input logic [STAGES-1:0][MOD_W-1:0]     acc_vec
);
  localparam int OUT_W = INT_W + 1;

  AST_N_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_int >= INT_W'(3)) |->
      ((out_n + OUT_W'(3) >= OUT_W'(cfg_int)) && (out_n <= OUT_W'(cfg_int) + OUT_W'(4)))); // R1

  AST_FRAC0_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_frac == '0 && !dith_on) |-> (out_n == OUT_W'(cfg_int))); // R3

  AST_RESID_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vec[0] < cfg_mod) && (acc_vec[1] < cfg_mod) && (acc_vec[2] < cfg_mod)); // R4

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> (acc_vec == '0)); // R5

  AST_CNTRST_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_reset |=> (!out_valid && acc_vec == '0)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !upd_strobe && !cnt_reset) |=>
      ($stable(out_n) && $stable(acc_vec))); // R7
endmodule

bind sdm_fracn_top sdm_fracn_chk #(
  .INT_W  (INT_W),
  .FRAC_W (FRAC_W),
  .MOD_W  (MOD_W),
  .STAGES (STAGES)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_reset  (cnt_reset),
  .upd_strobe (upd_strobe),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_n      (out_n),
  .cfg_int    (cfg_int),
  .cfg_frac   (cfg_frac),
  .cfg_mod    (cfg_mod),
  .dith_on    (dith_on),
  .acc_vec    (acc_vec)
);

// File: tb/sdm_fracn_top_tb_top.sv
module sdm_fracn_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_reset;
  logic        upd_strobe;
  logic [8:0]  int_val;
  logic [11:0] frac_val;
  logic [11:0] mod_val;
  logic        dither_en;
  logic        out_valid;
  logic        out_ready;
  logic [9:0]  out_n;

  int total = 0;
  int bad   = 0;
  int seq     [4096];
  int ref_seq [4096];
  int got;
  int stall_hits;
  int stall_bad;

  always #2 clk = ~clk;

  sdm_fracn_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_reset  (cnt_reset),
    .upd_strobe (upd_strobe),
    .int_val    (int_val),
    .frac_val   (frac_val),
    .mod_val    (mod_val),
    .dither_en  (dither_en),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_n      (out_n)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int iv, input int fv, input int mv, input bit d);
    @(negedge clk);
    int_val    = iv[8:0];
    frac_val   = fv[11:0];
    mod_val    = mv[11:0];
    dither_en  = d;
    upd_strobe = 1'b1;
    @(negedge clk);
    upd_strobe = 1'b0;
  endtask

  task automatic collect(input int n, input bit stall);
    bit prev_stall = 1'b0;
    int prev = 0;
    got = 0;
    stall_hits = 0;
    stall_bad = 0;
    for (int it = 0; it < n * 3 + 20 && got < n; it++) begin
      out_ready = stall ? ((it % 3) != 1) : 1'b1;
      if (prev_stall) begin
        stall_hits++;
        if (int'(out_n) != prev) stall_bad++;
      end
      prev_stall = out_valid && !out_ready;
      prev = int'(out_n);
      if (out_valid && out_ready) begin
        seq[got] = int'(out_n);
        got++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  task automatic check_bounds(input int iv, input int fv, input int mv, input int n, input string tag);
    longint s = 0;
    bit ok_sum = 1'b1;
    bit ok_rng = 1'b1;
    longint a_sum = 0, e_sum = 0, a_rng = 0;
    for (int m = 1; m <= got; m++) begin
      longint base;
      s += seq[m-1];
      base = longint'(m) * iv + (longint'(m) * fv) / mv;
      if (ok_sum && (s < base - 1 || s > base + 2)) begin
        ok_sum = 1'b0; a_sum = s; e_sum = base;
      end
      if (ok_rng && (seq[m-1] < iv - 3 || seq[m-1] > iv + 4)) begin
        ok_rng = 1'b0; a_rng = seq[m-1];
      end
    end
    chk(got == n, {tag, " R7 count accepted"}, got, n);
    chk(ok_sum, {tag, " R2 running sum band"}, a_sum, e_sum);
    chk(ok_rng, {tag, " R1 value window"}, a_rng, iv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_reset = 1'b0; upd_strobe = 1'b0; out_ready = 1'b0;
    int_val = '0; frac_val = '0; mod_val = 12'd2; dither_en = 1'b0;

    // R9: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 valid low in reset", out_valid, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b1, "R9 valid after reset", out_valid, 1);
    chk(out_n == 10'd0, "R9 default value", out_n, 0);

    // R2 / R1: sweep of every FRAC for small moduli
    for (int mv = 2; mv <= 9; mv++) begin
      for (int fv = 0; fv < mv; fv++) begin
        load_cfg(100, fv, mv, 1'b0);
        collect(6 * mv + 10, 1'b0);
        check_bounds(100, fv, mv, 6 * mv + 10, "sweep");
      end
    end

    // R4: wide, non-power-of-two moduli
    load_cfg(300, 4094, 4095, 1'b0); collect(600, 1'b0);  check_bounds(300, 4094, 4095, 600, "R4 mod4095");
    load_cfg(37, 333, 1000, 1'b0);   collect(1000, 1'b0); check_bounds(37, 333, 1000, 1000, "R4 mod1000");
    load_cfg(200, 1, 4095, 1'b0);    collect(300, 1'b0);  check_bounds(200, 1, 4095, 300, "R4 smallfrac");

    // R3: zero fraction gives INT exactly, at the top of the INT range
    begin
      int bad_v = -1;
      load_cfg(511, 0, 4095, 1'b0); collect(200, 1'b0);
      for (int i = 0; i < got; i++) if (seq[i] != 511 && bad_v < 0) bad_v = seq[i];
      chk(bad_v < 0 && got == 200, "R3 frac zero exact", bad_v, 511);
    end

    // R7: stalls do not change the accepted sequence; held value stable
    load_cfg(50, 3, 7, 1'b0); collect(100, 1'b0);
    for (int i = 0; i < 100; i++) ref_seq[i] = seq[i];
    load_cfg(50, 3, 7, 1'b0); collect(100, 1'b1);
    chk(stall_hits > 0 && stall_bad == 0, "R7 value held during stall", stall_bad, 0);
    begin
      int mism = 0;
      for (int i = 0; i < 100; i++) if (seq[i] != ref_seq[i]) mism++;
      chk(mism == 0 && got == 100, "R7 stalled sequence matches", mism, 0);
    end

    // R5: restart after a different setting repeats the sequence
    load_cfg(80, 2, 5, 1'b1); collect(30, 1'b0);
    load_cfg(50, 3, 7, 1'b0); collect(100, 1'b0);
    begin
      int mism = 0;
      for (int i = 0; i < 100; i++) if (seq[i] != ref_seq[i]) mism++;
      chk(mism == 0, "R5 restart repeats sequence", mism, 0);
    end

    // R6: counter reset withdraws the output and restarts
    load_cfg(50, 3, 7, 1'b0); collect(40, 1'b0);
    cnt_reset = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 valid low after counter reset", out_valid, 0);
    cnt_reset = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 valid back after release", out_valid, 1);
    collect(100, 1'b0);
    begin
      int mism = 0;
      for (int i = 0; i < 100; i++) if (seq[i] != ref_seq[i]) mism++;
      chk(mism == 0, "R6 sequence restarts", mism, 0);
    end

    // R10: pins ignored without the strobe
    load_cfg(20, 0, 7, 1'b0);
    int_val = 9'd77; frac_val = 12'd5; mod_val = 12'd9; dither_en = 1'b1;
    collect(50, 1'b0);
    begin
      int bad_v = -1;
      for (int i = 0; i < got; i++) if (seq[i] != 20 && bad_v < 0) bad_v = seq[i];
      chk(bad_v < 0 && got == 50, "R10 pins ignored without strobe", bad_v, 20);
    end

    // R8: dither active at MOD >= 50, suppressed below
    load_cfg(40, 0, 50, 1'b1); collect(2000, 1'b0);
    begin
      int diff = 0;
      int out_rng = 0;
      for (int i = 0; i < got; i++) begin
        if (seq[i] != 40) diff++;
        if (seq[i] < 37 || seq[i] > 44) out_rng++;
      end
      chk(diff > 0, "R8 dither perturbs output", diff, 1);
      chk(out_rng == 0, "R8 R1 dithered window", out_rng, 0);
    end
    load_cfg(40, 0, 49, 1'b1); collect(300, 1'b0);
    begin
      int diff = 0;
      for (int i = 0; i < got; i++) if (seq[i] != 40) diff++;
      chk(diff == 0 && got == 300, "R8 dither ignored below minimum modulus", diff, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule